// File: doc/BRIEF.md
# Averaged Signed Current Accumulator

This block takes a stream of signed current samples and produces two results: an average current value that is refreshed once per fixed block of samples, and a running charge total. A host-programmable signed bias is taken off each sample as it arrives. The bias-corrected samples are summed. When a block completes, the floor of the block mean is clamped into the sample range and published as a left-justified 16-bit word. One cycle later the published value is integrated into a saturating 16-bit two's-complement charge register.

The integration is done in fixed point. Every update adds `average * CHG_NUM` units of `2^-FRAC_W` charge LSB to a combined charge-and-residue value. The fractional residue is kept between updates, so sub-LSB charge is carried forward and not lost. Charging current (positive samples) raises the charge register and discharging current lowers it. The host can load the charge register at any time. A load clears the residue, and accumulation continues from the loaded value.

With the default settings (12-bit samples, blocks of 128, `FRAC_W`=16, `CHG_NUM`=4) and a sample rate near 1.46 kHz, one update occurs about every 88 ms. One current LSB held for an hour then adds close to 2.5 charge LSBs.

Top module: `current_accum`

## Requirements
- R1: After reset, `cur_word`, `acc_out` and `upd_pulse` are 0, the bias is 0 and the fractional residue is 0.
- R2: Each sample accepted while `smp_valid` is high has the signed bias subtracted before it enters the block sum. A bias written with `bias_wr` applies to samples accepted in later cycles. A sample accepted in the same cycle as the write still uses the old bias.
- R3: Every 2^AVG_LOG2 accepted samples, the block mean is published. The mean is the floor of the sum divided by 2^AVG_LOG2 (rounding toward minus infinity). `upd_pulse` is high for exactly the one cycle after the clock edge that accepts the last sample. `cur_word` changes only at that edge. Cycles with `smp_valid` low change nothing.
- R4: A block mean above 2047 is published as 2047, and one below -2048 is published as -2048. The value never wraps.
- R5: `cur_word` holds the 12-bit mean in bits 15:4, with bit 15 as the sign, and bits 3:0 read as zero.
- R6: At the edge that ends the cycle in which `upd_pulse` is high, the charge value (`acc_out` as the integer part, plus a FRAC_W-bit residue) grows by `mean*CHG_NUM/2^FRAC_W` exactly. The integer part is the floor of the combined value, and the remainder is kept as the residue. `acc_out` changes at no other time except a host load.
- R7: If an update would take the integer part above 32767 or below -32768, `acc_out` is set to that limit and the residue to 0.
- R8: A cycle with `acc_wr` high loads `acc_wdata` into `acc_out` at the next edge and clears the residue. Later updates add to the loaded value.
- R9: When `acc_wr` is high in the same cycle as `upd_pulse`, the host load wins and that update is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 12 | Signed current sample |
| bias_wr | input | 1 | Bias write strobe |
| bias_wdata | input | 8 | Signed bias value |
| acc_wr | input | 1 | Charge register write strobe |
| acc_wdata | input | 16 | Value loaded into the charge register |
| cur_word | output | 16 | Published mean, left-justified |
| acc_out | output | 16 | Signed charge register |
| upd_pulse | output | 1 | One-cycle flag: a mean was just published |

## Verification
The assertions assume that `smp_valid`, `acc_wr` and `bias_wr` are held low while reset is asserted, so that the first `$past` after reset compares against a quiet block. They also take the host load value as arbitrary, which means the direction checks on charge are skipped in any cycle that carries a load. The stimulus changes inputs only on falling edges and keeps every strobe low during reset. Its random samples are drawn inside the 12-bit range and its biases inside the 8-bit range. Directed loads close to both charge limits, combined with extreme biases, drive the mean clamp and the charge saturation.

// File: rtl/current_accum_pkg.sv
package current_accum_pkg;

  // Clamp a signed value into the range of a w-bit two's-complement number.
  function automatic longint sat_signed(input longint v, input int w);
    longint hi;
    longint lo;
    hi = (longint'(1) <<< (w - 1)) - longint'(1);
    lo = -(longint'(1) <<< (w - 1));
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

endpackage

// File: rtl/current_accum_avg.sv
module current_accum_avg
  import current_accum_pkg::*;
#(
  parameter int SMP_W    = 12,
  parameter int BIAS_W   = 8,
  parameter int AVG_LOG2 = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [SMP_W-1:0]  smp_data,
  input  logic              bias_wr,
  input  logic [BIAS_W-1:0] bias_wdata,
  output logic [SMP_W-1:0]  avg_q,
  output logic              pub_q,
  output logic              blk_last,
  output logic              clamp_hit
);
  localparam int DIFF_W = ((SMP_W > BIAS_W) ? SMP_W : BIAS_W) + 1;
  localparam int SUM_W  = DIFF_W + AVG_LOG2;
  localparam logic [AVG_LOG2-1:0] CNT_LAST = '1;

  logic signed [BIAS_W-1:0] bias_q;
  logic signed [SUM_W-1:0]  sum_q;
  logic [AVG_LOG2-1:0]      cnt_q;
  longint sum_nxt, avg_raw, avg_sat;

  always_comb begin
    sum_nxt = longint'(sum_q) + longint'($signed(smp_data)) - longint'(bias_q);
    avg_raw = sum_nxt >>> AVG_LOG2;
    avg_sat = sat_signed(avg_raw, SMP_W);
  end

  assign blk_last  = smp_valid && (cnt_q == CNT_LAST);
  assign clamp_hit = blk_last && (avg_sat != avg_raw);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bias_q <= '0;
      sum_q  <= '0;
      cnt_q  <= '0;
      avg_q  <= '0;
      pub_q  <= 1'b0;
    end else begin
      pub_q <= blk_last;
      if (bias_wr) bias_q <= bias_wdata;
      if (smp_valid) begin
        cnt_q <= cnt_q + 1'b1;
        if (blk_last) begin
          sum_q <= '0;
          avg_q <= avg_sat[SMP_W-1:0];
        end else begin
          sum_q <= sum_nxt[SUM_W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/current_accum_integ.sv
module current_accum_integ
  import current_accum_pkg::*;
#(
  parameter int SMP_W   = 12,
  parameter int ACC_W   = 16,
  parameter int FRAC_W  = 16,
  parameter int CHG_NUM = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  logic [SMP_W-1:0] avg,
  input  logic             host_wr,
  input  logic [ACC_W-1:0] host_data,
  output logic [ACC_W-1:0] acc_q,
  output logic [FRAC_W-1:0] frac_q,
  output logic             sat_hit
);
  longint tot_now, tot_nxt, whole, whole_sat;
  logic   over;

  always_comb begin
    tot_now   = (longint'($signed(acc_q)) <<< FRAC_W) + longint'({1'b0, frac_q});
    tot_nxt   = tot_now + longint'($signed(avg)) * longint'(CHG_NUM);
    whole     = tot_nxt >>> FRAC_W;
    whole_sat = sat_signed(whole, ACC_W);
    over      = (whole_sat != whole);
  end

  assign sat_hit = upd && !host_wr && over;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q  <= '0;
      frac_q <= '0;
    end else if (host_wr) begin
      acc_q  <= host_data;
      frac_q <= '0;
    end else if (upd) begin
      acc_q  <= whole_sat[ACC_W-1:0];
      frac_q <= over ? '0 : tot_nxt[FRAC_W-1:0];
    end
  end
endmodule

// File: rtl/current_accum.sv
module current_accum #(
  parameter int SMP_W      = 12,
  parameter int BIAS_W     = 8,
  parameter int AVG_LOG2   = 7,
  parameter int ACC_W      = 16,
  parameter int FRAC_W     = 16,
  parameter int CHG_NUM    = 4,
  parameter int CUR_WORD_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  smp_valid,
  input  logic [SMP_W-1:0]      smp_data,
  input  logic                  bias_wr,
  input  logic [BIAS_W-1:0]     bias_wdata,
  input  logic                  acc_wr,
  input  logic [ACC_W-1:0]      acc_wdata,
  output logic [CUR_WORD_W-1:0] cur_word,
  output logic [ACC_W-1:0]      acc_out,
  output logic                  upd_pulse
);
  localparam int PAD_W = CUR_WORD_W - SMP_W;

  logic [SMP_W-1:0]  avg_q;
  logic              blk_last;
  logic              clamp_hit;
  logic              acc_sat_hit;
  logic [FRAC_W-1:0] frac_q;

  current_accum_avg #(
    .SMP_W(SMP_W), .BIAS_W(BIAS_W), .AVG_LOG2(AVG_LOG2)
  ) u_avg (
    .clk(clk), .rst_n(rst_n),
    .smp_valid(smp_valid), .smp_data(smp_data),
    .bias_wr(bias_wr), .bias_wdata(bias_wdata),
    .avg_q(avg_q), .pub_q(upd_pulse),
    .blk_last(blk_last), .clamp_hit(clamp_hit)
  );

  current_accum_integ #(
    .SMP_W(SMP_W), .ACC_W(ACC_W), .FRAC_W(FRAC_W), .CHG_NUM(CHG_NUM)
  ) u_integ (
    .clk(clk), .rst_n(rst_n),
    .upd(upd_pulse), .avg(avg_q),
    .host_wr(acc_wr), .host_data(acc_wdata),
    .acc_q(acc_out), .frac_q(frac_q), .sat_hit(acc_sat_hit)
  );

  generate
    if (PAD_W > 0) begin : g_pad
      assign cur_word = {avg_q, {PAD_W{1'b0}}};
    end else begin : g_nopad
      assign cur_word = avg_q;
    end
  endgenerate
endmodule

// File: rtl/current_accum_chk.sv
module current_accum_chk #(
  parameter int SMP_W      = 12,
  parameter int ACC_W      = 16,
  parameter int FRAC_W     = 16,
  parameter int CUR_WORD_W = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  blk_last,
  input logic                  clamp_hit,
  input logic                  acc_sat_hit,
  input logic                  acc_wr,
  input logic [ACC_W-1:0]      acc_wdata,
  input logic [CUR_WORD_W-1:0] cur_word,
  input logic [ACC_W-1:0]      acc_out,
  input logic [FRAC_W-1:0]     frac_q,
  input logic                  upd_pulse
);
  localparam logic [SMP_W-1:0] AVG_MAX = {1'b0, {(SMP_W-1){1'b1}}};
  localparam logic [SMP_W-1:0] AVG_MIN = {1'b1, {(SMP_W-1){1'b0}}};
  localparam logic [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  assert_pub_follows_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
    blk_last |=> upd_pulse);

  assert_cur_only_on_pub_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_word) |-> upd_pulse);

  assert_clamp_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clamp_hit |=> (cur_word[CUR_WORD_W-1 -: SMP_W] == AVG_MAX ||
                   cur_word[CUR_WORD_W-1 -: SMP_W] == AVG_MIN));

  assert_acc_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(acc_wr) && !$past(upd_pulse)) |-> $stable(acc_out));

  assert_charge_up_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_pulse && !acc_wr && !cur_word[CUR_WORD_W-1]) |=>
      ($signed(acc_out) >= $signed($past(acc_out))));

  assert_charge_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_pulse && !acc_wr && cur_word[CUR_WORD_W-1]) |=>
      ($signed(acc_out) <= $signed($past(acc_out))));

  assert_sat_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_sat_hit |=> (frac_q == '0 && (acc_out == ACC_MAX || acc_out == ACC_MIN)));

  assert_host_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_wr |=> (acc_out == $past(acc_wdata) && frac_q == '0));

  assert_load_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && upd_pulse) |=> (acc_out == $past(acc_wdata)));
endmodule

bind current_accum current_accum_chk #(
  .SMP_W(SMP_W), .ACC_W(ACC_W), .FRAC_W(FRAC_W), .CUR_WORD_W(CUR_WORD_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .blk_last(blk_last), .clamp_hit(clamp_hit),
  .acc_sat_hit(acc_sat_hit), .acc_wr(acc_wr), .acc_wdata(acc_wdata),
  .cur_word(cur_word), .acc_out(acc_out), .frac_q(frac_q), .upd_pulse(upd_pulse)
);

// File: tb/current_accum_bench.sv
`timescale 1ns/1ps
module current_accum_bench;
  localparam int  AVG_LOG2 = 7;
  localparam int  NBLK     = 1 << AVG_LOG2;
  localparam int  FRAC_W   = 6;
  localparam int  CHG_NUM  = 5;
  localparam longint ONE   = longint'(1) << FRAC_W;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic [11:0] smp_data = '0;
  logic        bias_wr = 1'b0;
  logic [7:0]  bias_wdata = '0;
  logic        acc_wr = 1'b0;
  logic [15:0] acc_wdata = '0;
  logic [15:0] cur_word;
  logic [15:0] acc_out;
  logic        upd_pulse;

  current_accum #(
    .AVG_LOG2(AVG_LOG2), .FRAC_W(FRAC_W), .CHG_NUM(CHG_NUM)
  ) u_current_accum (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .bias_wr(bias_wr), .bias_wdata(bias_wdata), .acc_wr(acc_wr),
    .acc_wdata(acc_wdata), .cur_word(cur_word), .acc_out(acc_out),
    .upd_pulse(upd_pulse)
  );

  always #4 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  // Reference state
  int     m_bias = 0;
  longint m_sum = 0;
  int     m_cnt = 0;
  int     m_cur = 0;
  bit     m_pend = 1'b0;
  longint m_chg = 0;

  function automatic longint fdiv(input longint a, input longint b);
    if (a >= 0) return a / b;
    return -((-a + b - 1) / b);
  endfunction

  function automatic int mean_of(input longint s);
    longint q;
    q = fdiv(s, NBLK);
    if (q > 2047) q = 2047;
    if (q < -2048) q = -2048;
    return int'(q);
  endfunction

  task automatic chk(input string tag, input string what, input longint got, input longint exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic step(input string tag, input bit v, input int d,
                      input bit bw, input int bd, input bit aw, input int ad);
    longint w;
    @(negedge clk);
    smp_valid  = v;
    smp_data   = d[11:0];
    bias_wr    = bw;
    bias_wdata = bd[7:0];
    acc_wr     = aw;
    acc_wdata  = ad[15:0];
    @(posedge clk);
    #1;
    if (aw) m_chg = longint'(ad) * ONE;
    else if (m_pend) begin
      m_chg = m_chg + longint'(m_cur) * CHG_NUM;
      w = fdiv(m_chg, ONE);
      if (w > 32767) m_chg = 32767 * ONE;
      if (w < -32768) m_chg = -32768 * ONE;
    end
    m_pend = 1'b0;
    if (v) begin
      m_sum = m_sum + d - m_bias;
      m_cnt++;
      if (m_cnt == NBLK) begin
        m_cur = mean_of(m_sum);
        m_sum = 0;
        m_cnt = 0;
        m_pend = 1'b1;
      end
    end
    if (bw) m_bias = bd;
    chk(tag, "cur_word", longint'(cur_word), longint'((m_cur & 32'hFFF) << 4));
    chk(tag, "acc_out", longint'($signed(acc_out)), fdiv(m_chg, ONE));
    chk(tag, "upd_pulse", longint'(upd_pulse), longint'(m_pend));
  endtask

  // Runs until one block completes; samples in [lo, lo+spread], valid with prob pct
  task automatic run_block(input string tag, input int lo, input int spread, input int pct);
    int left;
    left = NBLK - m_cnt;
    while (left > 0) begin
      if (int'($urandom_range(99)) < pct) begin
        step(tag, 1'b1, lo + int'($urandom_range(spread)), 1'b0, 0, 1'b0, 0);
        left--;
      end else begin
        step(tag, 1'b0, int'($urandom_range(4095)) - 2048, 1'b0, 0, 1'b0, 0);
      end
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000 && !done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: got %0d cycles expected below 200000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1", "cur_word", longint'(cur_word), 0);
    chk("R1", "acc_out", longint'(acc_out), 0);
    chk("R1", "upd_pulse", longint'(upd_pulse), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R3/R5: constant block
    run_block("R3", 100, 0, 100);
    // R2: bias subtracted
    step("R2", 1'b0, 0, 1'b1, 20, 1'b0, 0);
    run_block("R2", 100, 0, 100);
    // R2: bias written in the same cycle as a sample
    step("R2", 1'b1, 500, 1'b1, -50, 1'b0, 0);
    run_block("R2", -300, 600, 100);
    // R3: gaps in the strobe
    run_block("R3", -1000, 2000, 40);
    // R4: clamp high, then low
    step("R4", 1'b0, 0, 1'b1, -128, 1'b0, 0);
    run_block("R4", 2047, 0, 100);
    step("R4", 1'b0, 0, 1'b1, 127, 1'b0, 0);
    run_block("R4", -2048, 0, 100);
    // R5: negative floor mean (-0.5 -> -1)
    step("R5", 1'b0, 0, 1'b1, 0, 1'b0, 0);
    for (int i = 0; i < NBLK; i++) step("R5", 1'b1, -(i % 2), 1'b0, 0, 1'b0, 0);
    // R8: host load mid-block, accumulation continues
    run_block("R8", 10, 5, 100);
    step("R8", 1'b1, 30, 1'b0, 0, 1'b1, 1000);
    run_block("R8", 30, 20, 100);
    step("R8", 1'b0, 0, 1'b0, 0, 1'b0, 0);
    // R7: saturation at both limits
    step("R7", 1'b0, 0, 1'b1, -128, 1'b1, 32600);
    for (int k = 0; k < 3; k++) run_block("R7", 2047, 0, 100);
    step("R7", 1'b0, 0, 1'b1, 127, 1'b1, -32600);
    for (int k = 0; k < 3; k++) run_block("R7", -2048, 0, 100);
    // R9: host load coincides with the update
    step("R9", 1'b0, 0, 1'b1, 0, 1'b0, 0);
    run_block("R9", 500, 100, 100);
    step("R9", 1'b0, 0, 1'b0, 0, 1'b1, 555);
    step("R9", 1'b0, 0, 1'b0, 0, 1'b0, 0);
    // R6: random blocks with random biases and sub-LSB residue
    for (int k = 0; k < 12; k++) begin
      step("R6", 1'b0, 0, 1'b1, int'($urandom_range(255)) - 128, 1'b0, 0);
      run_block("R6", -2048, 4095, 70);
    end
    for (int k = 0; k < 4; k++) run_block("R6", 3, 2, 100);
    step("R6", 1'b0, 0, 1'b0, 0, 1'b0, 0);

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule